// File: doc/BRIEF.md
# Remote Buffer Transfer Controller

This block lets a host move bytes between its register port and a local buffer memory without addressing each location itself. The host programs a 16-bit start address, a 16-bit byte count and a small configuration (byte or 16-bit transfers, little- or big-endian packing), then writes a 3-bit command that opens either a read or a write transfer. Each access to the data-port register then moves one byte or one word. The internal current address advances by the transfer size and the remaining count falls by the same amount.

When the remaining count reaches zero, the transfer closes and a one-cycle completion pulse is raised. Data-port accesses after that have no effect until a new command is issued. A command with its top bit set aborts at once and takes precedence over the lower bits. An abort leaves the current address where the transfer stopped and clears the remaining count. The host can read back the current address, the remaining count and the configuration through the same register port.

Top module: `rdma_ctrl`

## Requirements
- R1: After reset, the current address and the remaining count read back as 0, no read data is valid and the completion output is low.
- R2: Command 3'b001 opens a read transfer and 3'b010 opens a write transfer. Either one loads the current address from the programmed start address and the remaining count from the programmed count.
- R3: In byte mode (configuration bit 0 clear), each accepted data-port access moves one byte at the current address, adds 1 to the address and subtracts 1 from the remaining count.
- R4: In word mode (configuration bit 0 set), each accepted access moves two bytes at the address with bit 0 cleared. It adds 2 to the address and subtracts 2 from the remaining count, and the count stops at 0 instead of wrapping.
- R5: The access that brings the remaining count to 0 ends the transfer. The completion output is high for exactly the following cycle, and later data-port accesses leave the address, the count and the memory unchanged.
- R6: A start command issued with a programmed count of 0 moves no data. It raises the completion pulse in the next cycle and loads the start address into the current address.
- R7: Any command with bit 2 set aborts. The controller goes idle, the remaining count becomes 0, the current address keeps its value and no completion pulse is raised, whatever bits 1:0 hold.
- R8: Commands 3'b000 and 3'b011 have no effect: an open transfer continues and its count and address are unchanged.
- R9: Word packing follows configuration bit 1. When it is 0 (little-endian), data bits 7:0 go to the even byte. When it is 1 (big-endian), data bits 15:8 go to the even byte. Reads unpack the same way.
- R10: A byte-mode data read returns the byte in bits 7:0 with bits 15:8 at zero.
- R11: Every register read returns its data with the valid flag high in the second cycle after the read strobe is sampled, and the valid flag is high for nothing else.
- R12: A data-port access in the wrong direction, or with no transfer open, is ignored. Such a read returns 0.
- R13: Register offsets are: 0 command (write), 1 and 2 start address low/high (write) and current address low/high (read), 3 and 4 count low/high (write) and remaining count low/high (read), 5 configuration (read and write), 6 data port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 16 | Write data (8 bits for control registers, 16 bits for the data port) |
| reg_rdata | output | 16 | Registered read data |
| reg_rvalid | output | 1 | Read data valid |
| xfer_done | output | 1 | One-cycle transfer completion pulse |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume that only the data port moves data, so each clock edge sees at most one command or data access. The stimulus drives one strobe per cycle on the falling edge and holds it for exactly one cycle. Word-mode transfers are started only at even addresses, which keeps the expected packing unambiguous. A behavioural reference model in the bench follows every strobe and compares the completion pulse and read data cycle by cycle.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} rdma_state_e;

  localparam logic [3:0] OFS_CMD      = 4'd0;
  localparam logic [3:0] OFS_START_LO = 4'd1;
  localparam logic [3:0] OFS_START_HI = 4'd2;
  localparam logic [3:0] OFS_CNT_LO   = 4'd3;
  localparam logic [3:0] OFS_CNT_HI   = 4'd4;
  localparam logic [3:0] OFS_CFG      = 4'd5;
  localparam logic [3:0] OFS_DATA     = 4'd6;

  localparam logic [1:0] OP_READ  = 2'b01;
  localparam logic [1:0] OP_WRITE = 2'b10;

  typedef struct packed {
    logic big;
    logic word;
  } rdma_cfg_t;
endpackage

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        wbyte,
  output logic [ADDR_W-1:0] start_addr,
  output logic [CNT_W-1:0]  prog_count,
  output rdma_cfg_t         cfg
);
  logic [15:0] start16, count16;

  always_ff @(posedge clk) begin
    if (rst) begin
      start16 <= '0;
      count16 <= '0;
      cfg     <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_START_LO: start16[7:0]  <= wbyte;
        OFS_START_HI: start16[15:8] <= wbyte;
        OFS_CNT_LO:   count16[7:0]  <= wbyte;
        OFS_CNT_HI:   count16[15:8] <= wbyte;
        OFS_CFG:      cfg           <= rdma_cfg_t'(wbyte[1:0]);
        default: ;
      endcase
    end
  end

  assign start_addr = ADDR_W'(start16);
  assign prog_count = CNT_W'(count16);

  // R13: configuration changes only through a write at its own offset
  a_r13_cfg_hold: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && reg_addr == OFS_CFG) |=> $stable(cfg));
endmodule

// File: rtl/rdma_byte_ram.sv
module rdma_byte_ram #(
  parameter int DEPTH = 512,
  parameter int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic             re,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wd,
  output logic [7:0]       q
);
  logic [7:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
    if (re) q <= mem[idx];
  end
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [2:0]        cmd_bits,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic              word,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  prog_count,
  output rdma_state_e       state,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [CNT_W-1:0]  remain,
  output logic              wr_grant,
  output logic              rd_grant,
  output logic              done
);
  logic              is_start, is_abort, acc;
  logic [CNT_W-1:0]  cnt_step, cnt_next;
  logic [ADDR_W-1:0] addr_step;

  always_comb begin
    is_abort  = cmd_wr && cmd_bits[2];
    is_start  = cmd_wr && !cmd_bits[2] &&
                (cmd_bits[1:0] == OP_READ || cmd_bits[1:0] == OP_WRITE);
    wr_grant  = data_wr && (state == ST_WRITE);
    rd_grant  = data_rd && (state == ST_READ);
    acc       = wr_grant || rd_grant;
    cnt_step  = word ? CNT_W'(2) : CNT_W'(1);
    addr_step = word ? ADDR_W'(2) : ADDR_W'(1);
    cnt_next  = (remain <= cnt_step) ? '0 : remain - cnt_step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (is_abort) begin
        state  <= ST_IDLE;
        remain <= '0;
      end else if (is_start) begin
        cur_addr <= start_addr;
        remain   <= prog_count;
        if (prog_count == '0) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          state <= (cmd_bits[1:0] == OP_READ) ? ST_READ : ST_WRITE;
        end
      end else if (acc) begin
        cur_addr <= cur_addr + addr_step;
        remain   <= cnt_next;
        if (cnt_next == '0) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  a_r3_byte_step: assert property (@(posedge clk) disable iff (rst)
    (acc && !word) |=> (cur_addr == $past(cur_addr) + ADDR_W'(1)));

  a_r4_word_step: assert property (@(posedge clk) disable iff (rst)
    (acc && word) |=> (cur_addr == $past(cur_addr) + ADDR_W'(2)));

  a_r5_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_IDLE && remain == '0));

  a_r6_zero_count: assert property (@(posedge clk) disable iff (rst)
    (is_start && prog_count == '0) |=> (done && state == ST_IDLE));

  a_r7_abort: assert property (@(posedge clk) disable iff (rst)
    is_abort |=> (state == ST_IDLE && remain == '0 && !done && $stable(cur_addr)));

  a_r8_ignored_cmd: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_bits[2] && (cmd_bits[1:0] == 2'b00 || cmd_bits[1:0] == 2'b11))
      |=> ($stable(state) && $stable(remain) && $stable(cur_addr)));

  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cmd_wr) |=> ($stable(remain) && $stable(cur_addr)));
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl
  import rdma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int MEM_BYTES = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        reg_rvalid,
  output logic        xfer_done
);
  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int IDX_W  = MEM_AW - 1;
  localparam int LANES  = 2;

  logic [ADDR_W-1:0] start_addr, cur_addr;
  logic [CNT_W-1:0]  prog_count, remain;
  rdma_cfg_t         cfg;
  rdma_state_e       state;
  logic              wr_grant, rd_grant;
  logic [15:0]       cur16, rem16;

  rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .wbyte(reg_wdata[7:0]), .start_addr(start_addr),
    .prog_count(prog_count), .cfg(cfg)
  );

  rdma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst),
    .cmd_wr(reg_wr && reg_addr == OFS_CMD), .cmd_bits(reg_wdata[2:0]),
    .data_wr(reg_wr && reg_addr == OFS_DATA),
    .data_rd(reg_rd && reg_addr == OFS_DATA),
    .word(cfg.word), .start_addr(start_addr), .prog_count(prog_count),
    .state(state), .cur_addr(cur_addr), .remain(remain),
    .wr_grant(wr_grant), .rd_grant(rd_grant), .done(xfer_done)
  );

  // Byte lanes: lane 0 holds even addresses, lane 1 odd addresses
  logic [7:0] lane_wd [LANES];
  logic [7:0] lane_q  [LANES];
  logic       lane_we [LANES];

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      always_comb begin
        if (cfg.word)
          lane_wd[l] = ((l == 0) ^ cfg.big) ? reg_wdata[7:0] : reg_wdata[15:8];
        else
          lane_wd[l] = reg_wdata[7:0];
        lane_we[l] = wr_grant && (cfg.word || cur_addr[0] == 1'(l));
      end

      rdma_byte_ram #(.DEPTH(MEM_BYTES / LANES), .IDX_W(IDX_W)) u_ram (
        .clk(clk), .we(lane_we[l]), .re(rd_grant),
        .idx(cur_addr[MEM_AW-1:1]), .wd(lane_wd[l]), .q(lane_q[l])
      );
    end
  endgenerate

  // Read pipeline: stage 1 alongside the RAM read, stage 2 is the output register
  logic        s1_valid, s1_data, s1_word, s1_big, s1_lane;
  logic [15:0] s1_regval, regval, fmt;

  assign cur16 = 16'(cur_addr);
  assign rem16 = 16'(remain);

  always_comb begin
    case (reg_addr)
      OFS_START_LO: regval = {8'h00, cur16[7:0]};
      OFS_START_HI: regval = {8'h00, cur16[15:8]};
      OFS_CNT_LO:   regval = {8'h00, rem16[7:0]};
      OFS_CNT_HI:   regval = {8'h00, rem16[15:8]};
      OFS_CFG:      regval = {14'h0, cfg};
      default:      regval = 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_data   <= 1'b0;
      s1_word   <= 1'b0;
      s1_big    <= 1'b0;
      s1_lane   <= 1'b0;
      s1_regval <= '0;
    end else begin
      s1_valid  <= reg_rd;
      s1_data   <= rd_grant;
      s1_word   <= cfg.word;
      s1_big    <= cfg.big;
      s1_lane   <= cur_addr[0];
      s1_regval <= regval;
    end
  end

  always_comb begin
    if (s1_word)
      fmt = s1_big ? {lane_q[0], lane_q[1]} : {lane_q[1], lane_q[0]};
    else
      fmt = {8'h00, s1_lane ? lane_q[1] : lane_q[0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rvalid <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      reg_rvalid <= s1_valid;
      reg_rdata  <= s1_data ? fmt : s1_regval;
    end
  end

  a_r11_read_latency: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> ##1 reg_rvalid);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> ##1 !reg_rvalid);

  a_r12_wrong_dir: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_DATA && state != ST_READ) |=> ##1 (reg_rdata == 16'h0000));
endmodule

// File: tb/sim_rdma_ctrl.sv
module sim_rdma_ctrl;
  localparam int MEMB = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reg_rvalid;
  logic        xfer_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rdma_ctrl u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .xfer_done(xfer_done)
  );

  // ---------------- behavioural reference model ----------------
  int m_mem [MEMB];
  int m_state, m_cur, m_rem, m_start, m_cnt, m_cfg;
  int s_rv, s_rd, m_rv, m_rd, m_done;

  function automatic int step_of();
    return (m_cfg & 1) ? 2 : 1;
  endfunction

  task automatic m_advance();
    int st = step_of();
    m_cur = (m_cur + st) & 16'hffff;
    m_rem = (m_rem <= st) ? 0 : m_rem - st;
    if (m_rem == 0) begin m_state = 0; m_done = 1; end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_cur = 0; m_rem = 0; m_start = 0; m_cnt = 0; m_cfg = 0;
      s_rv = 0; s_rd = 0; m_rv = 0; m_rd = 0; m_done = 0;
      for (int i = 0; i < MEMB; i++) m_mem[i] = 0;
    end else begin
      int a, v, op;
      m_rv = s_rv; m_rd = s_rd; m_done = 0; s_rv = 0;
      a = m_cur % MEMB;
      if (reg_rd) begin
        s_rv = 1;
        case (reg_addr)
          1: v = m_cur & 255;
          2: v = m_cur >> 8;
          3: v = m_rem & 255;
          4: v = m_rem >> 8;
          5: v = m_cfg;
          6: begin
            if (m_state == 1) begin
              if (m_cfg & 1) begin
                a = a & ~1;
                v = (m_cfg & 2) ? (m_mem[a] << 8) | m_mem[a+1] : (m_mem[a+1] << 8) | m_mem[a];
              end else v = m_mem[a];
              m_advance();
            end else v = 0;
          end
          default: v = 0;
        endcase
        s_rd = v;
      end
      if (reg_wr) begin
        case (reg_addr)
          0: begin
            op = reg_wdata & 7;
            if (op >= 4) begin m_state = 0; m_rem = 0; end
            else if (op == 1 || op == 2) begin
              m_cur = m_start; m_rem = m_cnt;
              if (m_cnt == 0) begin m_state = 0; m_done = 1; end
              else m_state = op;
            end
          end
          1: m_start = (m_start & 16'hff00) | (reg_wdata & 255);
          2: m_start = (m_start & 255) | ((reg_wdata & 255) << 8);
          3: m_cnt = (m_cnt & 16'hff00) | (reg_wdata & 255);
          4: m_cnt = (m_cnt & 255) | ((reg_wdata & 255) << 8);
          5: m_cfg = reg_wdata & 3;
          6: if (m_state == 2) begin
            if (m_cfg & 1) begin
              a = a & ~1;
              if (m_cfg & 2) begin m_mem[a] = reg_wdata >> 8; m_mem[a+1] = reg_wdata & 255; end
              else begin m_mem[a] = reg_wdata & 255; m_mem[a+1] = reg_wdata >> 8; end
            end else m_mem[a] = reg_wdata & 255;
            m_advance();
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      check(xfer_done == 1'(m_done), "R5 done pulse vs model", int'(xfer_done), m_done);
      check(reg_rvalid == 1'(m_rv), "R11 read valid vs model", int'(reg_rvalid), m_rv);
      if (m_rv != 0)
        check(int'(reg_rdata) == m_rd, "R9 read data vs model", int'(reg_rdata), m_rd);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input int exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
    check(reg_rvalid && int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic setup(input int start, input int cnt, input int cfg);
    wr(4'd1, 16'(start & 255)); wr(4'd2, 16'(start >> 8));
    wr(4'd3, 16'(cnt & 255));   wr(4'd4, 16'(cnt >> 8));
    wr(4'd5, 16'(cfg));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!xfer_done && !reg_rvalid, "R1 outputs after reset", int'(xfer_done), 0);
    rd_chk(4'd1, 0, "R1 current address low");
    rd_chk(4'd3, 0, "R1 remaining count low");

    // R3/R5 byte write of 5 bytes at 0x0010
    setup(16'h0010, 5, 0);
    wr(4'd0, 16'h0002);
    rd_chk(4'd3, 5, "R2 count loaded");
    for (int i = 0; i < 5; i++) begin
      wr(4'd6, 16'(8'h11 + i));
      if (i == 4) check(xfer_done, "R5 done after last access", int'(xfer_done), 1);
    end
    rd_chk(4'd1, 8'h15, "R3 address advanced by 1 per byte");
    wr(4'd6, 16'h00EE);
    rd_chk(4'd1, 8'h15, "R5 access after completion ignored");

    // R10 byte read back, sixth byte never written
    setup(16'h0010, 6, 0);
    wr(4'd0, 16'h0001);
    for (int i = 0; i < 5; i++) rd_chk(4'd6, 8'h11 + i, "R10 byte read data");
    rd_chk(4'd6, 0, "R5 ignored write left memory untouched");
    rd_chk(4'd1, 8'h16, "R3 read address advanced");

    // R9 little-endian word write at 0x0100
    setup(16'h0100, 4, 1);
    wr(4'd0, 16'h0002);
    wr(4'd6, 16'hA1B2); wr(4'd6, 16'hC3D4);
    setup(16'h0100, 4, 0);
    wr(4'd0, 16'h0001);
    rd_chk(4'd6, 8'hB2, "R9 little-endian even byte");
    rd_chk(4'd6, 8'hA1, "R9 little-endian odd byte");
    rd_chk(4'd6, 8'hD4, "R9 little-endian even byte 2");
    rd_chk(4'd6, 8'hC3, "R9 little-endian odd byte 2");
    rd_chk(4'd2, 8'h01, "R13 current address high");

    // R9 big-endian word write at 0x0200
    setup(16'h0200, 2, 3);
    wr(4'd0, 16'h0002);
    wr(4'd6, 16'h1122);
    setup(16'h0200, 2, 0);
    wr(4'd0, 16'h0001);
    rd_chk(4'd6, 8'h11, "R9 big-endian even byte");
    rd_chk(4'd6, 8'h22, "R9 big-endian odd byte");
    setup(16'h0100, 2, 3);
    wr(4'd0, 16'h0001);
    rd_chk(4'd6, 16'hB2A1, "R9 big-endian word read");
    setup(16'h0100, 2, 1);
    wr(4'd0, 16'h0001);
    rd_chk(4'd6, 16'hA1B2, "R9 little-endian word read");

    // R4 odd count in word mode saturates
    setup(16'h0300, 3, 1);
    wr(4'd0, 16'h0002);
    wr(4'd6, 16'h5566);
    rd_chk(4'd3, 1, "R4 count minus 2");
    wr(4'd6, 16'h7788);
    check(xfer_done, "R4 done on saturated count", int'(xfer_done), 1);
    rd_chk(4'd3, 0, "R4 count stops at zero");
    rd_chk(4'd1, 8'h04, "R4 address advanced by 2");

    // R7 abort with low bits set
    setup(16'h0400, 10, 0);
    wr(4'd0, 16'h0002);
    rd_chk(4'd2, 8'h04, "R2 start address loaded");
    wr(4'd6, 16'h0001); wr(4'd6, 16'h0002);
    wr(4'd0, 16'h0006);
    check(!xfer_done, "R7 no done on abort", int'(xfer_done), 0);
    rd_chk(4'd3, 0, "R7 count cleared");
    rd_chk(4'd1, 8'h02, "R7 address kept");
    wr(4'd6, 16'h0003);
    rd_chk(4'd1, 8'h02, "R12 write after abort ignored");

    // R8 ignored commands
    setup(16'h0500, 4, 0);
    wr(4'd0, 16'h0002);
    wr(4'd6, 16'h0044);
    wr(4'd0, 16'h0000);
    rd_chk(4'd3, 3, "R8 command 000 ignored");
    wr(4'd0, 16'h0003);
    rd_chk(4'd3, 3, "R8 command 011 ignored");
    wr(4'd6, 16'h0045);
    rd_chk(4'd3, 2, "R8 transfer still open");
    wr(4'd0, 16'h0004);

    // R6 zero count
    setup(16'h0600, 0, 0);
    wr(4'd0, 16'h0001);
    check(xfer_done, "R6 done on zero count", int'(xfer_done), 1);
    rd_chk(4'd2, 8'h06, "R6 start address loaded");

    // R12 wrong direction / idle read
    setup(16'h0010, 3, 0);
    wr(4'd0, 16'h0001);
    wr(4'd6, 16'h0099);
    rd_chk(4'd3, 3, "R12 write during read ignored");
    wr(4'd0, 16'h0004);
    rd_chk(4'd6, 0, "R12 idle data read returns zero");
    rd_chk(4'd1, 8'h10, "R12 idle read leaves address");

    // R13 configuration readback
    wr(4'd5, 16'h0003);
    rd_chk(4'd5, 3, "R13 configuration readback");

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule